// File: doc/BRIEF.md
# Serial Port Flow Control Gate

This block sits beside one serial port's transmitter and receiver. It decides, each cycle, whether the transmitter may start the next ordinary data character, and it drives the signals that slow down the far-end sender. Transmit throttling can come from three modem lines, from software XON/XOFF characters in the received stream, and from the port's own XOFF transmission. On the receive side the block drives the RTS and DTR levels, gates incoming data on DSR, and asks the transmitter to insert XON or XOFF characters. Serialisation is left to the UART that uses these signals.

Software programs four settings through a small write port: a transmit mask, a receive mask, the XON character and the XOFF character. Any mix of mask bits may be enabled at once. When a mask is all zeros, that direction has no flow control. The three modem inputs are asynchronous and pass through a synchroniser before any decision uses them.

Top module: `sfc_gate`

## Requirements
- R1: After reset, tx_allow, rts_out, dtr_out and rx_accept are 1, inj_req is 0, both masks are 0, and the XON and XOFF characters are 8'h11 and 8'h13.
- R2: Transmit mask bit 0 blocks tx_allow while CTS is low, bit 1 while DSR is low and bit 2 while DCD is low. A modem input change reaches tx_allow on the second rising clock edge after it, not on the first. Clearing a bit removes the effect of its line.
- R3: With transmit mask bit 3 set, an accepted received character equal to the XOFF character drops tx_allow from the next cycle. An XON character raises it again. Both matched characters are consumed (rx_out_valid is 0 for them), and all other characters pass through. With bit 3 clear, nothing is matched.
- R4: With transmit mask bit 3 set and bit 4 clear, an acknowledged XOFF injection holds tx_allow low until an XON injection is acknowledged. With bit 4 set, sending XOFF does not affect tx_allow.
- R5: With transmit mask bit 5 set, rts_out goes high one cycle after tx_req, inj_req or a non-empty transmitter is seen. tx_allow rises only one cycle later than that. rts_out and tx_allow fall together once tx_empty=1 with no request pending.
- R6: A buf_high pulse marks the receiver throttled and a buf_low pulse clears it. While it is throttled, receive mask bit 0 drives rts_out low and bit 1 drives dtr_out low. With both bits clear, neither line moves.
- R7: With receive mask bit 2 set and DSR low (after synchronisation), rx_accept is 0 and no received character is passed on or matched.
- R8: With receive mask bit 3 set, buf_high raises inj_req with inj_is_xoff=1 and inj_char equal to the XOFF character on the next cycle. The request holds until inj_ack.
- R9: A buf_low pulse requests XON (inj_is_xoff=0, inj_char equal to the XON character) only if an XOFF has been acknowledged since the last XON. Otherwise it cancels any pending XOFF and requests nothing.
- R10: Config writes select the target with cfg_sel: 0 is the transmit mask, 1 the receive mask, 2 the XON character and 3 the XOFF character. New characters apply to both matching and injection.
- R11: When several transmit sources are enabled, tx_allow is 1 only when none of them blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target (0 tx mask, 1 rx mask, 2 XON, 3 XOFF) |
| cfg_wdata | input | 8 | Configuration write data |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | 8 | Received character |
| buf_high | input | 1 | Receive buffer crossed its high mark (pulse) |
| buf_low | input | 1 | Receive buffer fell below its low mark (pulse) |
| tx_req | input | 1 | A data character is waiting to be sent |
| tx_empty | input | 1 | Transmitter holds no character, last one fully sent |
| inj_ack | input | 1 | Transmitter has taken the injected character |
| tx_allow | output | 1 | Ordinary data may be sent |
| rts_out | output | 1 | RTS drive level |
| dtr_out | output | 1 | DTR drive level |
| rx_accept | output | 1 | Received data is being accepted |
| rx_out_valid | output | 1 | Character passed on as data |
| rx_out_char | output | 8 | Character passed on |
| inj_req | output | 1 | Request to insert a flow character |
| inj_is_xoff | output | 1 | 1 for XOFF, 0 for XON |
| inj_char | output | 8 | Character to insert |

## Verification
The bench checks that a modem line takes exactly two edges to reach tx_allow. A design missing the synchroniser would react one cycle early, and one with an extra stage would react one cycle late. It checks that a buf_low arriving before any XOFF was acknowledged produces no XON and withdraws the pending XOFF; a careless design would send an unmatched XON or leave the XOFF standing. Reprogrammed characters must take effect in both the matcher and the injector, and the old defaults must stop matching. In half-duplex mode, tx_allow must trail RTS by a cycle, and RTS must stay up until the transmitter reports empty.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int CHAR_W   = 8;
  localparam int TXM_W    = 6;
  localparam int RXM_W    = 4;
  // transmit mask bit positions
  localparam int TB_CTS   = 0;
  localparam int TB_DSR   = 1;
  localparam int TB_DCD   = 2;
  localparam int TB_SWFC  = 3;
  localparam int TB_XCONT = 4;
  localparam int TB_HDX   = 5;
  // receive mask bit positions
  localparam int RB_RTS   = 0;
  localparam int RB_DTR   = 1;
  localparam int RB_DSRQ  = 2;
  localparam int RB_SWFC  = 3;

  typedef enum logic [1:0] {
    SEL_TXM  = 2'd0,
    SEL_RXM  = 2'd1,
    SEL_XON  = 2'd2,
    SEL_XOFF = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOT = W * STAGES;

  logic [TOT-1:0] chain_q;
  logic [TOT-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[TOT-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_nx;
  end

  assign q = chain_q[TOT-1 -: W];
endmodule

// File: rtl/sfc_tx_gate.sv
module sfc_tx_gate
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TXM_W-1:0] txm,
  input  logic             cts_s,
  input  logic             dsr_s,
  input  logic             dcd_s,
  input  logic             hit_xon,
  input  logic             hit_xoff,
  input  logic             tx_req,
  input  logic             tx_empty,
  input  logic             inj_req,
  input  logic             inj_ack,
  input  logic             inj_is_xoff,
  output logic             tx_allow,
  output logic             hd_rts
);
  logic remote_q, remote_nx;
  logic hold_q, hold_nx;
  logic rts_q, rts_nx;
  logic rdy_q, rdy_nx;
  logic modem_ok;
  logic busy;
  logic ack_xoff, ack_xon;

  assign ack_xoff = inj_ack & inj_req & inj_is_xoff;
  assign ack_xon  = inj_ack & inj_req & ~inj_is_xoff;
  assign busy     = tx_req | inj_req | ~tx_empty;

  always_comb begin
    remote_nx = remote_q;
    if (!txm[TB_SWFC])  remote_nx = 1'b0;
    else if (hit_xoff)  remote_nx = 1'b1;
    else if (hit_xon)   remote_nx = 1'b0;

    hold_nx = hold_q;
    if (!(txm[TB_SWFC] && !txm[TB_XCONT])) hold_nx = 1'b0;
    else if (ack_xoff)                     hold_nx = 1'b1;
    else if (ack_xon)                      hold_nx = 1'b0;

    if (txm[TB_HDX] && busy) begin
      rts_nx = 1'b1;
      rdy_nx = rts_q;
    end else begin
      rts_nx = 1'b0;
      rdy_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remote_q <= 1'b0;
      hold_q   <= 1'b0;
      rts_q    <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      remote_q <= remote_nx;
      hold_q   <= hold_nx;
      rts_q    <= rts_nx;
      rdy_q    <= rdy_nx;
    end
  end

  assign modem_ok = ~(txm[TB_CTS] & ~cts_s) & ~(txm[TB_DSR] & ~dsr_s)
                  & ~(txm[TB_DCD] & ~dcd_s);
  assign tx_allow = modem_ok & ~remote_q & ~hold_q & (~txm[TB_HDX] | rdy_q);
  assign hd_rts   = rts_q;

  a_r5_rts_leads_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (txm[TB_HDX] && $rose(tx_allow)) |-> $past(hd_rts));

  a_r4_halt_after_xoff: assert property (@(posedge clk) disable iff (!rst_n)
    (txm[TB_SWFC] && !txm[TB_XCONT] && ack_xoff)
      |=> (!tx_allow || !txm[TB_SWFC] || txm[TB_XCONT]));

  a_r3_xoff_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (txm[TB_SWFC] && hit_xoff && !hit_xon) |=> (!tx_allow || !txm[TB_SWFC]));
endmodule

// File: rtl/sfc_rx_throttle.sv
module sfc_rx_throttle
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RXM_W-1:0]  rxm,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              buf_high,
  input  logic              buf_low,
  input  logic              inj_ack,
  output logic              rts_thr,
  output logic              dtr_thr,
  output logic              inj_req,
  output logic              inj_is_xoff,
  output logic [CHAR_W-1:0] inj_char
);
  logic thr_q, thr_nx;
  logic pxoff_q, pxoff_nx;
  logic pxon_q, pxon_nx;
  logic sent_q, sent_nx;

  always_comb begin
    thr_nx = thr_q;
    if (buf_high)     thr_nx = 1'b1;
    else if (buf_low) thr_nx = 1'b0;

    pxoff_nx = pxoff_q;
    pxon_nx  = pxon_q;
    sent_nx  = sent_q;
    if (!rxm[RB_SWFC]) begin
      pxoff_nx = 1'b0;
      pxon_nx  = 1'b0;
      sent_nx  = 1'b0;
    end else begin
      if (inj_ack && inj_req) begin
        if (pxoff_q) begin
          sent_nx  = 1'b1;
          pxoff_nx = 1'b0;
        end else begin
          sent_nx  = 1'b0;
          pxon_nx  = 1'b0;
        end
      end
      if (buf_high) begin
        pxon_nx  = 1'b0;
        pxoff_nx = ~sent_nx;
      end else if (buf_low) begin
        pxoff_nx = 1'b0;
        pxon_nx  = sent_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= 1'b0;
      pxoff_q <= 1'b0;
      pxon_q  <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      thr_q   <= thr_nx;
      pxoff_q <= pxoff_nx;
      pxon_q  <= pxon_nx;
      sent_q  <= sent_nx;
    end
  end

  assign rts_thr     = ~(rxm[RB_RTS] & thr_q);
  assign dtr_thr     = ~(rxm[RB_DTR] & thr_q);
  assign inj_req     = pxoff_q | pxon_q;
  assign inj_is_xoff = pxoff_q;
  assign inj_char    = pxoff_q ? xoff_char : xon_char;

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_req && !inj_ack && !buf_high && !buf_low && rxm[RB_SWFC])
      |=> (inj_req || !rxm[RB_SWFC]));

  a_r9_xon_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inj_req) && !inj_is_xoff) |-> $past(buf_low));
endmodule

// File: rtl/sfc_gate.sv
module sfc_gate
  import sfc_pkg::*;
#(
  parameter int              SYNC_STAGES  = 2,
  parameter logic [CHAR_W-1:0] XON_DEFAULT  = 8'h11,
  parameter logic [CHAR_W-1:0] XOFF_DEFAULT = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              dcd_in,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              buf_high,
  input  logic              buf_low,
  input  logic              tx_req,
  input  logic              tx_empty,
  input  logic              inj_ack,
  output logic              tx_allow,
  output logic              rts_out,
  output logic              dtr_out,
  output logic              rx_accept,
  output logic              rx_out_valid,
  output logic [CHAR_W-1:0] rx_out_char,
  output logic              inj_req,
  output logic              inj_is_xoff,
  output logic [CHAR_W-1:0] inj_char
);
  localparam int N_MODEM = 3;

  // reset release synchroniser
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // configuration
  logic [TXM_W-1:0]  txm_q, txm_nx;
  logic [RXM_W-1:0]  rxm_q, rxm_nx;
  logic [CHAR_W-1:0] xon_q, xon_nx;
  logic [CHAR_W-1:0] xoff_q, xoff_nx;
  cfg_sel_e          sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    txm_nx  = txm_q;
    rxm_nx  = rxm_q;
    xon_nx  = xon_q;
    xoff_nx = xoff_q;
    if (cfg_wr) begin
      unique case (sel)
        SEL_TXM:  txm_nx  = cfg_wdata[TXM_W-1:0];
        SEL_RXM:  rxm_nx  = cfg_wdata[RXM_W-1:0];
        SEL_XON:  xon_nx  = cfg_wdata;
        SEL_XOFF: xoff_nx = cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      txm_q  <= '0;
      rxm_q  <= '0;
      xon_q  <= XON_DEFAULT;
      xoff_q <= XOFF_DEFAULT;
    end else begin
      txm_q  <= txm_nx;
      rxm_q  <= rxm_nx;
      xon_q  <= xon_nx;
      xoff_q <= xoff_nx;
    end
  end

  // modem line synchronisation
  logic [N_MODEM-1:0] modem_s;
  logic cts_s, dsr_s, dcd_s;

  sfc_sync #(.W(N_MODEM), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({dcd_in, dsr_in, cts_in}),
    .q     (modem_s)
  );
  assign cts_s = modem_s[0];
  assign dsr_s = modem_s[1];
  assign dcd_s = modem_s[2];

  // receive path: acceptance and flow character matching
  logic rx_take, hit_xon, hit_xoff, swfc_on;
  assign rx_accept    = ~(rxm_q[RB_DSRQ] & ~dsr_s);
  assign rx_take      = rx_valid & rx_accept;
  assign swfc_on      = txm_q[TB_SWFC];
  assign hit_xon      = rx_take & swfc_on & (rx_char == xon_q);
  assign hit_xoff     = rx_take & swfc_on & (rx_char == xoff_q);
  assign rx_out_valid = rx_take & ~hit_xon & ~hit_xoff;
  assign rx_out_char  = rx_char;

  logic hd_rts, rts_thr, dtr_thr;

  sfc_rx_throttle u_rx (
    .clk         (clk),
    .rst_n       (rst_i),
    .rxm         (rxm_q),
    .xon_char    (xon_q),
    .xoff_char   (xoff_q),
    .buf_high    (buf_high),
    .buf_low     (buf_low),
    .inj_ack     (inj_ack),
    .rts_thr     (rts_thr),
    .dtr_thr     (dtr_thr),
    .inj_req     (inj_req),
    .inj_is_xoff (inj_is_xoff),
    .inj_char    (inj_char)
  );

  sfc_tx_gate u_tx (
    .clk         (clk),
    .rst_n       (rst_i),
    .txm         (txm_q),
    .cts_s       (cts_s),
    .dsr_s       (dsr_s),
    .dcd_s       (dcd_s),
    .hit_xon     (hit_xon),
    .hit_xoff    (hit_xoff),
    .tx_req      (tx_req),
    .tx_empty    (tx_empty),
    .inj_req     (inj_req),
    .inj_ack     (inj_ack),
    .inj_is_xoff (inj_is_xoff),
    .tx_allow    (tx_allow),
    .hd_rts      (hd_rts)
  );

  assign rts_out = txm_q[TB_HDX] ? hd_rts : rts_thr;
  assign dtr_out = dtr_thr;

  a_r3_flow_chars_consumed: assert property (@(posedge clk) disable iff (!rst_i)
    (rx_out_valid && txm_q[TB_SWFC]) |-> (rx_out_char != xon_q && rx_out_char != xoff_q));

  a_r7_dsr_gates_data: assert property (@(posedge clk) disable iff (!rst_i)
    (rxm_q[RB_DSRQ] && !dsr_s) |-> !rx_out_valid);
endmodule

// File: tb/sfc_gate_test.sv
module sfc_gate_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic       cts_in, dsr_in, dcd_in;
  logic       rx_valid;
  logic [7:0] rx_char;
  logic       buf_high, buf_low, tx_req, tx_empty, inj_ack;
  logic       tx_allow, rts_out, dtr_out, rx_accept, rx_out_valid;
  logic [7:0] rx_out_char;
  logic       inj_req, inj_is_xoff;
  logic [7:0] inj_char;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sfc_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in),
    .rx_valid(rx_valid), .rx_char(rx_char), .buf_high(buf_high), .buf_low(buf_low),
    .tx_req(tx_req), .tx_empty(tx_empty), .inj_ack(inj_ack),
    .tx_allow(tx_allow), .rts_out(rts_out), .dtr_out(dtr_out), .rx_accept(rx_accept),
    .rx_out_valid(rx_out_valid), .rx_out_char(rx_out_char),
    .inj_req(inj_req), .inj_is_xoff(inj_is_xoff), .inj_char(inj_char)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] c, output logic passed);
    rx_valid = 1'b1; rx_char = c;
    #1 passed = rx_out_valid;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic pulse_high();
    buf_high = 1'b1; step(); buf_high = 1'b0;
  endtask

  task automatic pulse_low();
    buf_low = 1'b1; step(); buf_low = 1'b0;
  endtask

  task automatic ack();
    inj_ack = 1'b1; step(); inj_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_allow", {7'd0, tx_allow}, 8'd1);
    chk("R1 rts", {7'd0, rts_out}, 8'd1);
    chk("R1 dtr", {7'd0, dtr_out}, 8'd1);
    chk("R1 rx_accept", {7'd0, rx_accept}, 8'd1);
    chk("R1 inj_req", {7'd0, inj_req}, 8'd0);
  endtask

  task automatic t_modem();
    cfg(2'd0, 8'h01);
    cts_in = 1'b0; step();
    chk("R2 cts one edge", {7'd0, tx_allow}, 8'd1);
    step();
    chk("R2 cts two edges", {7'd0, tx_allow}, 8'd0);
    cts_in = 1'b1; step(2);
    chk("R2 cts restored", {7'd0, tx_allow}, 8'd1);
    cfg(2'd0, 8'h02); dsr_in = 1'b0; step(2);
    chk("R2 dsr block", {7'd0, tx_allow}, 8'd0);
    dsr_in = 1'b1; cfg(2'd0, 8'h04); dcd_in = 1'b0; step(2);
    chk("R2 dcd block", {7'd0, tx_allow}, 8'd0);
    cfg(2'd0, 8'h00);
    chk("R2 mask zero ignores dcd", {7'd0, tx_allow}, 8'd1);
    dcd_in = 1'b1; step(2);
    cfg(2'd0, 8'h07); cts_in = 1'b0; step(2);
    chk("R11 cts alone blocks", {7'd0, tx_allow}, 8'd0);
    cts_in = 1'b1; step(2);
    chk("R11 all lines up", {7'd0, tx_allow}, 8'd1);
    cfg(2'd0, 8'h00);
  endtask

  task automatic t_swfc();
    logic p;
    cfg(2'd0, 8'h08);
    send_rx(8'h13, p);
    chk("R3 xoff consumed", {7'd0, p}, 8'd0);
    chk("R3 xoff stops", {7'd0, tx_allow}, 8'd0);
    send_rx(8'h41, p);
    chk("R3 data passes", {7'd0, p}, 8'd1);
    chk("R3 still stopped", {7'd0, tx_allow}, 8'd0);
    send_rx(8'h11, p);
    chk("R3 xon consumed", {7'd0, p}, 8'd0);
    chk("R3 xon resumes", {7'd0, tx_allow}, 8'd1);
    cfg(2'd0, 8'h01); cts_in = 1'b0; step(2);
    cfg(2'd0, 8'h09);
    send_rx(8'h11, p);
    chk("R11 xon cannot override cts", {7'd0, tx_allow}, 8'd0);
    cts_in = 1'b1; step(2);
    cfg(2'd0, 8'h00);
    send_rx(8'h13, p);
    chk("R3 mode off passes xoff", {7'd0, p}, 8'd1);
    chk("R3 mode off no stop", {7'd0, tx_allow}, 8'd1);
  endtask

  task automatic t_inject();
    cfg(2'd0, 8'h08); cfg(2'd1, 8'h08);
    pulse_high();
    chk("R8 xoff req", {7'd0, inj_req}, 8'd1);
    chk("R8 is xoff", {7'd0, inj_is_xoff}, 8'd1);
    chk("R8 xoff char", inj_char, 8'h13);
    step();
    chk("R8 req held", {7'd0, inj_req}, 8'd1);
    ack();
    chk("R8 req cleared", {7'd0, inj_req}, 8'd0);
    chk("R4 halted after xoff", {7'd0, tx_allow}, 8'd0);
    pulse_low();
    chk("R9 xon req", {7'd0, inj_req}, 8'd1);
    chk("R9 is xon", {7'd0, inj_is_xoff}, 8'd0);
    chk("R9 xon char", inj_char, 8'h11);
    ack();
    chk("R4 resumed after xon", {7'd0, tx_allow}, 8'd1);
    cfg(2'd0, 8'h18);
    pulse_high(); ack();
    chk("R4 continue bit keeps tx", {7'd0, tx_allow}, 8'd1);
    pulse_low(); ack();
    chk("R9 clean", {7'd0, inj_req}, 8'd0);
  endtask

  task automatic t_no_xon();
    cfg(2'd1, 8'h08);
    pulse_low();
    chk("R9 low alone no req", {7'd0, inj_req}, 8'd0);
    pulse_high();
    chk("R9 xoff pending", {7'd0, inj_req}, 8'd1);
    pulse_low();
    chk("R9 pending xoff cancelled", {7'd0, inj_req}, 8'd0);
  endtask

  task automatic t_chars();
    logic p;
    cfg(2'd3, 8'h5A); cfg(2'd2, 8'h5B);
    cfg(2'd0, 8'h08); cfg(2'd1, 8'h08);
    pulse_high();
    chk("R10 new xoff char", inj_char, 8'h5A);
    ack();
    pulse_low();
    chk("R10 new xon char", inj_char, 8'h5B);
    ack();
    send_rx(8'h13, p);
    chk("R10 old xoff passes", {7'd0, p}, 8'd1);
    chk("R10 old xoff no stop", {7'd0, tx_allow}, 8'd1);
    send_rx(8'h5A, p);
    chk("R10 new xoff stops", {7'd0, tx_allow}, 8'd0);
    send_rx(8'h5B, p);
    chk("R10 new xon resumes", {7'd0, tx_allow}, 8'd1);
    cfg(2'd3, 8'h13); cfg(2'd2, 8'h11); cfg(2'd0, 8'h00); cfg(2'd1, 8'h00);
  endtask

  task automatic t_modem_out();
    cfg(2'd1, 8'h03);
    pulse_high();
    chk("R6 rts dropped", {7'd0, rts_out}, 8'd0);
    chk("R6 dtr dropped", {7'd0, dtr_out}, 8'd0);
    pulse_low();
    chk("R6 rts raised", {7'd0, rts_out}, 8'd1);
    chk("R6 dtr raised", {7'd0, dtr_out}, 8'd1);
    cfg(2'd1, 8'h00);
    pulse_high();
    chk("R6 mask zero rts", {7'd0, rts_out}, 8'd1);
    chk("R6 mask zero dtr", {7'd0, dtr_out}, 8'd1);
    pulse_low();
  endtask

  task automatic t_dsr_rx();
    logic p;
    cfg(2'd1, 8'h04); cfg(2'd0, 8'h08);
    dsr_in = 1'b0; step(2);
    chk("R7 accept low", {7'd0, rx_accept}, 8'd0);
    send_rx(8'h41, p);
    chk("R7 data dropped", {7'd0, p}, 8'd0);
    send_rx(8'h13, p);
    chk("R7 xoff ignored", {7'd0, tx_allow}, 8'd1);
    dsr_in = 1'b1; step(2);
    chk("R7 accept high", {7'd0, rx_accept}, 8'd1);
    send_rx(8'h41, p);
    chk("R7 data passes", {7'd0, p}, 8'd1);
    cfg(2'd1, 8'h00); cfg(2'd0, 8'h00);
  endtask

  task automatic t_halfdup();
    cfg(2'd0, 8'h20);
    chk("R5 rts idle low", {7'd0, rts_out}, 8'd0);
    chk("R5 tx idle blocked", {7'd0, tx_allow}, 8'd0);
    tx_req = 1'b1; step();
    chk("R5 rts raised", {7'd0, rts_out}, 8'd1);
    chk("R5 tx waits", {7'd0, tx_allow}, 8'd0);
    step();
    chk("R5 tx allowed", {7'd0, tx_allow}, 8'd1);
    tx_req = 1'b0; tx_empty = 1'b0; step(3);
    chk("R5 rts held while sending", {7'd0, rts_out}, 8'd1);
    tx_empty = 1'b1; step();
    chk("R5 rts dropped", {7'd0, rts_out}, 8'd0);
    chk("R5 tx dropped", {7'd0, tx_allow}, 8'd0);
    cfg(2'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h00;
    cts_in = 1'b1; dsr_in = 1'b1; dcd_in = 1'b1;
    rx_valid = 1'b0; rx_char = 8'h00; buf_high = 1'b0; buf_low = 1'b0;
    tx_req = 1'b0; tx_empty = 1'b1; inj_ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_modem();
    t_swfc();
    t_inject();
    t_no_xon();
    t_chars();
    t_modem_out();
    t_dsr_rx();
    t_halfdup();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule